// File: doc/BRIEF.md
# Sleep Control Register Decoder

This block holds a 16-bit power-management control register that software reaches at a fixed offset through a simple write/read port. Bit 13 of a write acts as a one-shot trigger and is never stored. When a write carries that bit, the block decodes the three-bit sleep-type field in bits 12:10 and issues one-cycle request pulses toward the platform's power sequencer. Type 0 asks for power-off and type 1 asks for suspend-to-RAM. A type that matches a configured hibernate code asks for suspend-to-disk, and a power-off request follows it.

Bit 0 of the register is an interrupt-enable flag. Besides ordinary writes, a pair of handshake inputs from the interrupt routing logic set and clear it. The block does not carry out any power transition itself. It only decodes and reports requests.

Top module: `pm_sleep_ctl`

## Requirements
- R1: A write is accepted when `wrEn` is 1, `addr` equals the control offset (default 4) and `accSize` is 1 (16-bit). An accepted write stores `wrData` with bit 13 forced to 0 at the next clock edge. `rdData` shows the stored value while `rdEn` is 1 with the same offset and size, and is 0 otherwise.
- R2: Bit 13 of the stored register always reads back as 0, including after a write that had it set.
- R3: An accepted write with bit 13 set and bits 12:10 equal to 0 gives a one-cycle `offReq` pulse in the cycle after the write.
- R4: An accepted write with bit 13 set and bits 12:10 equal to 1 gives a one-cycle `suspReq` pulse in the cycle after the write.
- R5: An accepted write with bit 13 set and bits 12:10 in the range 2..7 and equal to `hibCode` gives a `hibReq` pulse in the cycle after the write, and an `offReq` pulse in the cycle after that.
- R6: An accepted write with bit 13 clear, or with a sleep type of 2..7 that differs from `hibCode`, produces no request pulse.
- R7: When `hibCode` is 0 or 1, types 0 and 1 keep their power-off and suspend meaning and `hibReq` stays low.
- R8: `intrSet` sets bit 0 and `intrClr` clears it at the next edge. `intrSet` wins when both are 1. Both take precedence over bit 0 of a write in the same cycle.
- R9: A write with `accSize` other than 1 (0 = 8-bit, 2 = 32-bit, 3 = reserved) or with another address leaves the register unchanged and produces no pulse.
- R10: Reset clears the register to 0 and holds all request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W (4) | Access offset |
| accSize | input | 2 | Access width: 0 byte, 1 half, 2 word, 3 reserved |
| wrData | input | 16 | Write value |
| hibCode | input | 3 | Sleep type that means suspend-to-disk |
| intrSet | input | 1 | Sets interrupt-enable bit 0 |
| intrClr | input | 1 | Clears interrupt-enable bit 0 |
| rdData | output | 16 | Read value |
| offReq | output | 1 | Power-off request pulse |
| suspReq | output | 1 | Suspend-to-RAM request pulse |
| hibReq | output | 1 | Suspend-to-disk request pulse |

## Verification
The hardest case to reach is overlap. A hibernate write is followed at once by another triggering write, so the deferred power-off pulse coincides with a fresh request. A handshake on bit 0 also lands in the same cycle as a register write. Random stimulus gives high weight to accepted writes with bit 13 set. It draws `hibCode` mostly from 2..7 so that matches happen often. It also raises the handshake inputs freely, so these collisions come up many times. Directed steps cover a hibernate code of 0 or 1, the rejected access widths, and a foreign offset.

// File: rtl/pmsc_pkg.sv
package pmsc_pkg;
  localparam int REG_W     = 16;
  localparam int TRIG_BIT  = 13;
  localparam int TYPE_LSB  = 10;
  localparam int TYPE_W    = 3;
  localparam int IE_BIT    = 0;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  typedef struct packed {
    logic store;
    logic ieSet;
    logic ieClr;
    logic rdSel;
  } dpStrobe_t;
endpackage

// File: rtl/pmsc_control.sv
module pmsc_control
  import pmsc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CTL_OFFSET = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           accSize,
  input  logic [REG_W-1:0]     wrData,
  input  logic [TYPE_W-1:0]    hibCode,
  input  logic                 intrSet,
  input  logic                 intrClr,
  output dpStrobe_t            strobe,
  output logic                 offReq,
  output logic                 suspReq,
  output logic                 hibReq
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(CTL_OFFSET);

  logic              sel;
  logic              accepted;
  logic              trigger;
  logic [TYPE_W-1:0] sleepType;
  logic              wantOff;
  logic              wantSusp;
  logic              wantHib;

  assign sel       = (addr == OFFS) && (accSize == SZ_HALF);
  assign accepted  = wrEn && sel;
  assign trigger   = accepted && wrData[TRIG_BIT];
  assign sleepType = wrData[TYPE_LSB +: TYPE_W];

  always_comb begin
    wantOff  = 1'b0;
    wantSusp = 1'b0;
    wantHib  = 1'b0;
    if (trigger) begin
      case (sleepType)
        TYPE_W'(0): wantOff  = 1'b1;
        TYPE_W'(1): wantSusp = 1'b1;
        default:    wantHib  = (sleepType == hibCode);
      endcase
    end
  end

  always_comb begin
    strobe.store = accepted;
    strobe.ieSet = intrSet;
    strobe.ieClr = intrClr && !intrSet;
    strobe.rdSel = rdEn && sel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReq  <= 1'b0;
      suspReq <= 1'b0;
      hibReq  <= 1'b0;
    end else begin
      offReq  <= wantOff || hibReq;
      suspReq <= wantSusp;
      hibReq  <= wantHib;
    end
  end
endmodule

// File: rtl/pmsc_datapath.sv
module pmsc_datapath
  import pmsc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctlReg,
  output logic [REG_W-1:0] rdData
);
  localparam logic [REG_W-1:0] KEEP_MASK = ~(REG_W'(1) << TRIG_BIT);

  logic [REG_W-1:0] nextReg;

  always_comb begin
    nextReg = strobe.store ? (wrData & KEEP_MASK) : ctlReg;
    if (strobe.ieSet)      nextReg[IE_BIT] = 1'b1;
    else if (strobe.ieClr) nextReg[IE_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctlReg <= '0;
    else       ctlReg <= nextReg;
  end

  assign rdData = strobe.rdSel ? ctlReg : '0;
endmodule

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl
  import pmsc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CTL_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        accSize,
  input  logic [15:0]       wrData,
  input  logic [2:0]        hibCode,
  input  logic              intrSet,
  input  logic              intrClr,
  output logic [15:0]       rdData,
  output logic              offReq,
  output logic              suspReq,
  output logic              hibReq
);
  dpStrobe_t        strobe;
  logic [REG_W-1:0] ctlReg;

  pmsc_control #(.ADDR_W(ADDR_W), .CTL_OFFSET(CTL_OFFSET)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .accSize(accSize), .wrData(wrData), .hibCode(hibCode),
    .intrSet(intrSet), .intrClr(intrClr), .strobe(strobe),
    .offReq(offReq), .suspReq(suspReq), .hibReq(hibReq)
  );

  pmsc_datapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .ctlReg(ctlReg), .rdData(rdData)
  );
endmodule

// File: rtl/pm_sleep_ctl_chk.sv
module pm_sleep_ctl_chk #(
  parameter int ADDR_W     = 4,
  parameter int CTL_OFFSET = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        accSize,
  input logic [15:0]       wrData,
  input logic              intrSet,
  input logic              intrClr,
  input logic              offReq,
  input logic              suspReq,
  input logic              hibReq,
  input logic [15:0]       ctlReg
);
  logic hit;
  assign hit = wrEn && (addr == ADDR_W'(CTL_OFFSET)) && (accSize == 2'd1);

  assert_store_R1: assert property (@(posedge clk) disable iff (!rstN)
    hit && !intrSet && !intrClr |=> ctlReg == ($past(wrData) & 16'hDFFF));

  assert_trigger_dropped_R2: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> !ctlReg[13]);

  assert_off_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    hit && wrData[13] && wrData[12:10] == 3'd0 |=> offReq);

  assert_susp_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    hit && wrData[13] && wrData[12:10] == 3'd1 |=> suspReq);

  assert_hib_then_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    hibReq |=> offReq);

  assert_ie_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    intrSet |=> ctlReg[0]);

  assert_ie_clr_R8: assert property (@(posedge clk) disable iff (!rstN)
    intrClr && !intrSet |=> !ctlReg[0]);

  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hit && !intrSet && !intrClr |=> $stable(ctlReg));
endmodule

bind pm_sleep_ctl pm_sleep_ctl_chk #(.ADDR_W(ADDR_W), .CTL_OFFSET(CTL_OFFSET)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .accSize(accSize),
  .wrData(wrData), .intrSet(intrSet), .intrClr(intrClr), .offReq(offReq),
  .suspReq(suspReq), .hibReq(hibReq), .ctlReg(ctlReg)
);

// File: tb/sim_pm_sleep_ctl.sv
module sim_pm_sleep_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, intrSet = 1'b0, intrClr = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  accSize = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  hibCode = 3'd5;
  logic [15:0] rdData;
  logic        offReq, suspReq, hibReq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] expReg = '0;
  logic        expOff = 0, expSusp = 0, expHib = 0;

  always #5 clk = ~clk;

  pm_sleep_ctl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .accSize(accSize), .wrData(wrData), .hibCode(hibCode),
    .intrSet(intrSet), .intrClr(intrClr), .rdData(rdData),
    .offReq(offReq), .suspReq(suspReq), .hibReq(hibReq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(input logic r, input logic [3:0] a, input logic [1:0] s);
    return (r && a == 4'd4 && s == 2'd1) ? expReg : 16'h0;
  endfunction

  task automatic step(input logic w, input logic r, input logic [3:0] a, input logic [1:0] s,
                      input logic [15:0] d, input logic [2:0] hc, input logic st, input logic cl);
    logic hit, trig, nOff, nSusp, nHib;
    logic [2:0] t;
    wrEn = w; rdEn = r; addr = a; accSize = s; wrData = d; hibCode = hc;
    intrSet = st; intrClr = cl;
    @(posedge clk);
    hit   = w && a == 4'd4 && s == 2'd1;
    trig  = hit && d[13];
    t     = d[12:10];
    nOff  = (trig && t == 3'd0) || expHib;
    nSusp = trig && t == 3'd1;
    nHib  = trig && t >= 3'd2 && t == hc;
    if (hit) expReg = d & 16'hDFFF;
    if (st) expReg[0] = 1'b1;
    else if (cl) expReg[0] = 1'b0;
    expOff = nOff; expSusp = nSusp; expHib = nHib;
    @(negedge clk);
    chk(offReq == expOff, "R3", offReq, expOff);
    chk(suspReq == expSusp, "R4", suspReq, expSusp);
    chk(hibReq == expHib, "R5", hibReq, expHib);
    chk(rdData == expRead(r, a, s), "R1", rdData, expRead(r, a, s));
  endtask

  task automatic rd();
    step(0, 1, 4'd4, 2'd1, 16'h0, hibCode, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rdEn = 1; addr = 4'd4; accSize = 2'd1;
    @(negedge clk);
    chk(rdData == 16'h0 && !offReq && !suspReq && !hibReq, "R10", rdData, 0);
    rstN = 1;

    step(1, 1, 4'd4, 2'd1, 16'h1234, 3'd5, 0, 0); rd();
    chk(rdData == 16'h1234, "R1", rdData, 16'h1234);
    chk(!offReq && !suspReq && !hibReq, "R6", {offReq, suspReq, hibReq}, 0);

    step(1, 0, 4'd4, 2'd1, 16'h2C05, 3'd5, 0, 0);
    chk(!offReq && !suspReq && !hibReq, "R6", {offReq, suspReq, hibReq}, 0);
    rd();
    chk(rdData == 16'h0C05, "R2", rdData, 16'h0C05);

    step(1, 0, 4'd4, 2'd1, 16'h2000, 3'd5, 0, 0);
    chk(offReq == 1, "R3", offReq, 1);
    step(1, 0, 4'd4, 2'd1, 16'h2400, 3'd5, 0, 0);
    chk(suspReq == 1 && offReq == 0, "R4", {offReq, suspReq}, 1);

    step(1, 0, 4'd4, 2'd1, 16'h3800, 3'd6, 0, 0);
    chk(hibReq == 1 && offReq == 0, "R5", {hibReq, offReq}, 2);
    rd();
    chk(offReq == 1 && hibReq == 0, "R5", {hibReq, offReq}, 1);
    rd();
    chk(offReq == 0, "R5", offReq, 0);

    step(1, 0, 4'd4, 2'd1, 16'h2400, 3'd1, 0, 0);
    chk(suspReq == 1 && hibReq == 0, "R7", {suspReq, hibReq}, 2);
    step(1, 0, 4'd4, 2'd1, 16'h2000, 3'd0, 0, 0);
    chk(offReq == 1 && hibReq == 0, "R7", {offReq, hibReq}, 2);

    step(1, 0, 4'd4, 2'd1, 16'h0000, 3'd5, 1, 1); rd();
    chk(rdData == 16'h0001, "R8", rdData, 1);
    step(1, 0, 4'd4, 2'd1, 16'h0003, 3'd5, 0, 1); rd();
    chk(rdData == 16'h0002, "R8", rdData, 2);

    step(1, 0, 4'd4, 2'd0, 16'hFFFF, 3'd5, 0, 0); rd();
    chk(rdData == 16'h0002, "R9", rdData, 2);
    step(1, 0, 4'd4, 2'd2, 16'h2000, 3'd5, 0, 0);
    chk(!offReq, "R9", offReq, 0);
    step(1, 0, 4'd6, 2'd1, 16'h2000, 3'd5, 0, 0);
    chk(!offReq, "R9", offReq, 0);
    rd();
    chk(rdData == 16'h0002, "R9", rdData, 2);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      logic [3:0]  a;
      logic [1:0]  s;
      logic [2:0]  hc;
      d  = 16'($urandom);
      if ($urandom_range(3) != 0) d[13] = 1'b1;
      a  = ($urandom_range(7) != 0) ? 4'd4 : 4'($urandom);
      s  = ($urandom_range(7) != 0) ? 2'd1 : 2'($urandom);
      hc = ($urandom_range(7) != 0) ? 3'($urandom_range(7, 2)) : 3'($urandom_range(1));
      step(1'($urandom), 1'($urandom), a, s, d, hc,
           $urandom_range(5) == 0, $urandom_range(5) == 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R10 actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule